// File: doc/BRIEF.md
# Cross-Domain Periodic Interrupt Timer

This block is a periodic down-counter whose count register runs on its own slow timer clock. The register port, the timeout flag and the interrupt request sit on the bus clock. Software programs a reload value, then sets a run bit and an interrupt-enable bit. The counter loads the reload value and decrements once per timer clock. At zero it reloads, emits a one-cycle trigger pulse and raises a timeout event.

The timer side holds the event until the bus side has cleared it. This prevents a second event before software acknowledges the first. The flag clear returns to the timer clock through a toggle handshake. The live count crosses the other way as a held snapshot, so a read never returns a torn value.

The register port has four words at `wr_addr`/`rd_addr`: 0 holds the reload value, 1 holds the control bits, 2 holds status, and 3 holds the count (read-only). Reads are combinational. Writes take effect on the bus clock edge.

Top module: `xdom_pit`

## Requirements
- R1: After reset, all four register words read 0, and `irq_o`, `trig_o` and `wake_o` are low.
- R2: With control bit 0 (run) set, the counter loads the reload value (word 0, low CNT_W bits). It decrements once per timer clock, reaches 0 and reloads, so consecutive triggers are exactly reload+1 timer cycles apart.
- R3: Each wrap produces a `trig_o` pulse of exactly one timer cycle. Triggers continue whether or not the timeout flag is set.
- R4: Each accepted timeout sets status bit 0 within a few bus cycles. Writing a 1 to status bit 0 clears it on the next bus edge. Writing 0 leaves it unchanged.
- R5: `irq_o` is high exactly when status bit 0 is set and control bit 1 (interrupt enable) is set. Clearing control bit 1 drops `irq_o` on the next bus edge while the flag stays readable.
- R6: A timeout that occurs while the flag is still pending produces no further event. After a clear, `irq_o` rises again only at the next timeout.
- R7: With any reload value of 32 or more, a flag cleared promptly after each timeout never loses a later timeout.
- R8: Word 3 returns a recent snapshot of the counter that never exceeds the reload value. It reads 0 once the timer is stopped.
- R9: `wake_o`, driven from the timer clock, rises with the trigger of an accepted timeout. It falls within a few timer cycles after the flag is cleared.
- R10: Clearing the run bit zeroes the counter and holds `trig_o` low. Setting the run bit again restarts from the reload value, so the first trigger comes reload+1 timer cycles after the setting crosses over. Configuration writes to words 0 and 1 must be spaced at least four timer cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Register and interrupt clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus clock |
| tick_clk | input | 1 | Counter clock |
| tick_rst | input | 1 | Synchronous active-high reset, counter clock |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write word select |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read word select |
| rd_data | output | DATA_W | Read data (combinational) |
| irq_o | output | 1 | Interrupt request, bus clock |
| trig_o | output | 1 | One-cycle trigger per wrap, counter clock |
| wake_o | output | 1 | Pending-timeout wake indication, counter clock |

## Verification
The hardest situation to reach is a second timeout that arrives while the first flag is still pending. A related case is a clear issued just before the next wrap at the minimum reload value. The stimulus deliberately leaves the flag set across a full period. It then clears the flag and confirms that no delayed interrupt appears. After that, it runs several back-to-back periods at reload 32 and clears the flag as soon as each interrupt shows, so every clear handshake races the following wrap.

// File: rtl/xdom_pit_pkg.sv
package xdom_pit_pkg;

    localparam int ADDR_W        = 2;
    localparam int RUN_BIT       = 0;
    localparam int IE_BIT        = 1;
    localparam int FLAG_BIT      = 0;
    localparam int MIN_RELOAD    = 32;

    typedef enum logic [ADDR_W-1:0] {
        SEL_RELOAD = 2'd0,
        SEL_CTRL   = 2'd1,
        SEL_STAT   = 2'd2,
        SEL_COUNT  = 2'd3
    } sel_e;

    typedef struct packed {
        logic irq_en;
        logic run;
    } ctrl_t;

    // toggle lanes crossing between the clocks
    typedef struct packed {
        logic snap;
        logic clr;
        logic cfg;
    } to_tick_t;

    typedef struct packed {
        logic snap;
        logic ack;
        logic evt;
    } to_bus_t;

    function automatic logic edge_of(input logic now_v, input logic last_v);
        return now_v ^ last_v;
    endfunction

endpackage

// File: rtl/xdom_pit_sync.sv
module xdom_pit_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= '0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= '0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/xdom_pit_core.sv
module xdom_pit_core
    import xdom_pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  to_tick_t         tgl_in,
    input  logic             cfg_run,
    input  logic [CNT_W-1:0] cfg_reload,
    output to_bus_t          tgl_out,
    output logic [CNT_W-1:0] snap_val,
    output logic             trig_o,
    output logic             wake_o
);
    to_tick_t         sy, last;
    logic             run_q, trig_q, pend_q;
    logic [CNT_W-1:0] reload_q, cnt_q, snap_q;
    to_bus_t          out_q;
    logic             cfg_seen, clr_seen, snap_seen;

    xdom_pit_sync #(.WIDTH(3), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (tgl_in),
        .q   (sy)
    );

    assign cfg_seen  = edge_of(sy.cfg,  last.cfg);
    assign clr_seen  = edge_of(sy.clr,  last.clr);
    assign snap_seen = edge_of(sy.snap, last.snap);

    always_ff @(posedge clk) begin
        if (rst) begin
            last     <= '0;
            run_q    <= 1'b0;
            reload_q <= '0;
            cnt_q    <= '0;
            trig_q   <= 1'b0;
            pend_q   <= 1'b0;
            out_q    <= '0;
            snap_q   <= '0;
        end else begin
            last   <= sy;
            trig_q <= 1'b0;
            if (cfg_seen) begin
                run_q    <= cfg_run;
                reload_q <= cfg_reload;
            end
            if (cfg_seen && cfg_run && !run_q) begin
                cnt_q <= cfg_reload;
            end else if (cfg_seen && !cfg_run) begin
                cnt_q <= '0;
            end else if (run_q) begin
                if (cnt_q == '0) begin
                    cnt_q  <= reload_q;
                    trig_q <= 1'b1;
                    if (!pend_q) begin
                        pend_q    <= 1'b1;
                        out_q.evt <= ~out_q.evt;
                    end
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
            if (clr_seen) begin
                pend_q    <= 1'b0;
                out_q.ack <= ~out_q.ack;
            end
            if (snap_seen) begin
                snap_q     <= cnt_q;
                out_q.snap <= ~out_q.snap;
            end
        end
    end

    assign tgl_out  = out_q;
    assign snap_val = snap_q;
    assign trig_o   = trig_q;
    assign wake_o   = pend_q;

    // R3
    trig_single_chk: assert property (@(posedge clk) disable iff (rst)
        trig_q |=> !trig_q);

    // R10
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !run_q |=> !trig_q);

    // R6
    one_event_chk: assert property (@(posedge clk) disable iff (rst)
        (out_q.evt != $past(out_q.evt)) |-> !$past(pend_q));

    // R9
    wake_drop_chk: assert property (@(posedge clk) disable iff (rst)
        clr_seen |=> !wake_o);

    // R2
    cnt_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q && !cfg_seen && cnt_q == '0) |=> (cnt_q == $past(reload_q)));
endmodule

// File: rtl/xdom_pit_regs.sv
module xdom_pit_regs
    import xdom_pit_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_o,
    input  to_bus_t           tgl_in,
    input  logic [CNT_W-1:0]  snap_val,
    output to_tick_t          tgl_out,
    output logic              cfg_run,
    output logic [CNT_W-1:0]  cfg_reload
);
    localparam int PAD_W = DATA_W - CNT_W;

    to_bus_t          sy, last;
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] reload_q, count_q;
    logic             flag_q, busy_q, want_q;
    to_tick_t         out_q;
    logic             wr_reload, wr_ctrl, w1c, evt_seen, ack_seen, snap_seen, snap_idle;
    logic             unused_bits;

    xdom_pit_sync #(.WIDTH(3), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (tgl_in),
        .q   (sy)
    );

    assign wr_reload = wr_en && (sel_e'(wr_addr) == SEL_RELOAD);
    assign wr_ctrl   = wr_en && (sel_e'(wr_addr) == SEL_CTRL);
    assign w1c       = wr_en && (sel_e'(wr_addr) == SEL_STAT) && wr_data[FLAG_BIT];
    assign evt_seen  = edge_of(sy.evt,  last.evt);
    assign ack_seen  = edge_of(sy.ack,  last.ack);
    assign snap_seen = edge_of(sy.snap, last.snap);
    assign snap_idle = (out_q.snap == sy.snap);
    assign unused_bits = ^wr_data[DATA_W-1:CNT_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            last     <= '0;
            ctrl_q   <= '0;
            reload_q <= '0;
            count_q  <= '0;
            flag_q   <= 1'b0;
            busy_q   <= 1'b0;
            want_q   <= 1'b0;
            out_q    <= '0;
        end else begin
            last <= sy;
            if (wr_reload) reload_q <= wr_data[CNT_W-1:0];
            if (wr_ctrl) begin
                ctrl_q.run    <= wr_data[RUN_BIT];
                ctrl_q.irq_en <= wr_data[IE_BIT];
            end
            if (wr_reload || wr_ctrl) out_q.cfg <= ~out_q.cfg;

            if (evt_seen)  flag_q <= 1'b1;
            else if (w1c)  flag_q <= 1'b0;

            if (ack_seen) busy_q <= 1'b0;
            if (want_q && !busy_q) begin
                out_q.clr <= ~out_q.clr;
                busy_q    <= 1'b1;
                want_q    <= 1'b0;
            end
            if (w1c && flag_q && !evt_seen) want_q <= 1'b1;

            if (snap_idle) begin
                if (snap_seen) count_q <= snap_val;
                out_q.snap <= ~out_q.snap;
            end
        end
    end

    always_comb begin
        unique case (sel_e'(rd_addr))
            SEL_RELOAD: rd_data = {{PAD_W{1'b0}}, reload_q};
            SEL_CTRL:   rd_data = {{(DATA_W-2){1'b0}}, ctrl_q.irq_en, ctrl_q.run};
            SEL_STAT:   rd_data = {{(DATA_W-1){1'b0}}, flag_q};
            SEL_COUNT:  rd_data = {{PAD_W{1'b0}}, count_q};
            default:    rd_data = '0;
        endcase
    end

    assign irq_o      = flag_q & ctrl_q.irq_en;
    assign tgl_out    = out_q;
    assign cfg_run    = ctrl_q.run;
    assign cfg_reload = reload_q;

    // R4
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (w1c && !evt_seen) |=> !flag_q);

    // R4
    w0_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel_e'(wr_addr) == SEL_STAT && !wr_data[FLAG_BIT] && flag_q) |=> flag_q);

    // R5
    mask_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !wr_data[IE_BIT]) |=> !irq_o);
endmodule

// File: rtl/xdom_pit.sv
module xdom_pit
    import xdom_pit_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              bus_clk,
    input  logic              bus_rst,
    input  logic              tick_clk,
    input  logic              tick_rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_o,
    output logic              trig_o,
    output logic              wake_o
);
    to_tick_t         b2t;
    to_bus_t          t2b;
    logic             cfg_run;
    logic [CNT_W-1:0] cfg_reload, snap_val;

    xdom_pit_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk        (bus_clk),
        .rst        (bus_rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .irq_o      (irq_o),
        .tgl_in     (t2b),
        .snap_val   (snap_val),
        .tgl_out    (b2t),
        .cfg_run    (cfg_run),
        .cfg_reload (cfg_reload)
    );

    xdom_pit_core #(.CNT_W(CNT_W)) u_core (
        .clk        (tick_clk),
        .rst        (tick_rst),
        .tgl_in     (b2t),
        .cfg_run    (cfg_run),
        .cfg_reload (cfg_reload),
        .tgl_out    (t2b),
        .snap_val   (snap_val),
        .trig_o     (trig_o),
        .wake_o     (wake_o)
    );
endmodule

// File: tb/xdom_pit_test.sv
module xdom_pit_test;
    localparam int DW = 32;

    logic          bus_clk = 1'b0, tick_clk = 1'b0;
    logic          bus_rst = 1'b1, tick_rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          irq_o, trig_o, wake_o;

    int vectors = 0, miscompares = 0;
    int mon_mode = 0;   // 0 off, 1 expect quiet, 2 periodic
    int mon_period = 0, mon_phase = 0;
    bit mon_locked = 0;
    bit finished = 0;

    always #10 bus_clk = ~bus_clk;
    initial begin
        #7;
        forever #35 tick_clk = ~tick_clk;
    end

    xdom_pit uut (
        .bus_clk(bus_clk), .bus_rst(bus_rst), .tick_clk(tick_clk), .tick_rst(tick_rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq_o(irq_o), .trig_o(trig_o), .wake_o(wake_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge bus_clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge bus_clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
        @(negedge bus_clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic bus_wait(input int n);
        for (int i = 0; i < n; i++) @(negedge bus_clk);
    endtask

    task automatic tick_wait(input int n);
        for (int i = 0; i < n; i++) @(negedge tick_clk);
    endtask

    task automatic wait_trig(input int maxc, output int n);
        n = 0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge tick_clk);
            n++;
            if (trig_o === 1'b1) break;
        end
    endtask

    // timer-clock reference: trigger spacing and quiet periods
    always @(negedge tick_clk) begin
        if (mon_mode == 1) begin
            check(trig_o === 1'b0, "R10 trig held low while stopped", trig_o, 0);
        end else if (mon_mode == 2) begin
            if (!mon_locked) begin
                if (trig_o === 1'b1) begin
                    mon_locked = 1;
                    mon_phase  = 0;
                end
            end else begin
                mon_phase++;
                check(trig_o === (mon_phase == mon_period), "R2 R3 trig cadence",
                      trig_o, (mon_phase == mon_period));
                if (mon_phase == mon_period) mon_phase = 0;
            end
        end
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            vectors++; miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        int n;
        #504;
        bus_rst = 1'b0; tick_rst = 1'b0;
        bus_wait(2);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], d);
            check(d == 0, "R1 reset word", d, 0);
        end
        check(irq_o === 1'b0 && trig_o === 1'b0 && wake_o === 1'b0, "R1 outputs idle",
              {irq_o, trig_o, wake_o}, 0);

        // start with reload 40
        wr(2'd0, 40);
        bus_wait(16);
        mon_period = 41; mon_locked = 0; mon_mode = 2;
        wr(2'd1, 3);
        wait_trig(60, n);
        check(n >= 41 && n <= 46, "R10 first trig after start", n, 41);
        check(wake_o === 1'b1, "R9 wake with timeout", wake_o, 1);
        bus_wait(5);
        check(irq_o === 1'b1, "R5 irq on timeout", irq_o, 1);
        rd(2'd2, d);
        check(d == 1, "R4 flag set", d, 1);

        // write 0 has no effect
        wr(2'd2, 0);
        rd(2'd2, d);
        check(d == 1, "R4 write zero keeps flag", d, 1);

        // mask and unmask
        wr(2'd1, 1);
        check(irq_o === 1'b0, "R5 masked irq", irq_o, 0);
        rd(2'd2, d);
        check(d == 1, "R5 flag kept while masked", d, 1);
        bus_wait(16);
        wr(2'd1, 3);
        check(irq_o === 1'b1, "R5 unmasked irq", irq_o, 1);

        // second timeout while flag pending
        wait_trig(60, n);
        check(n <= 42, "R3 trig continues while pending", n, 41);
        bus_wait(6);
        wr(2'd2, 1);
        check(irq_o === 1'b0, "R4 w1c drops irq", irq_o, 0);
        bus_wait(12);
        check(irq_o === 1'b0, "R6 no stale second event", irq_o, 0);
        tick_wait(8);
        check(wake_o === 1'b0, "R9 wake falls after clear", wake_o, 0);
        wait_trig(60, n);
        bus_wait(5);
        check(irq_o === 1'b1, "R6 next timeout raises irq", irq_o, 1);

        // count readback
        for (int k = 0; k < 6; k++) begin
            tick_wait(5);
            rd(2'd3, d);
            check(d <= 40, "R8 count within reload", d, 40);
        end

        // stop
        wr(2'd2, 1);
        bus_wait(16);
        mon_mode = 0;
        wr(2'd1, 0);
        tick_wait(10);
        mon_mode = 1;
        tick_wait(100);
        rd(2'd3, d);
        check(d == 0, "R8 R10 count zero when stopped", d, 0);

        // minimum reload, back-to-back clears
        wr(2'd0, 32);
        bus_wait(16);
        mon_mode = 0;
        mon_period = 33; mon_locked = 0; mon_mode = 2;
        wr(2'd1, 3);
        wait_trig(60, n);
        check(n >= 33 && n <= 38, "R10 restart from reload", n, 33);
        for (int k = 0; k < 6; k++) begin
            if (k > 0) wait_trig(60, n);
            bus_wait(5);
            check(irq_o === 1'b1, "R7 timeout caught at reload 32", irq_o, 1);
            wr(2'd2, 1);
            check(irq_o === 1'b0, "R7 clear at reload 32", irq_o, 0);
        end

        mon_mode = 0;
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule